// File: doc/BRIEF.md
# Indirect-Access Clock Register File

This block holds the 64-byte register space of a real-time clock and reaches it through a host port with only two locations. A single select bit picks the location. With the bit low the host talks to a 6-bit index register. With the bit high it talks to a data window that reads and writes whichever internal byte the index names. Software first writes the index and then moves data through the window as often as it needs.

The space is divided into three groups. Indices 0 to 9 hold the time and calendar bytes. Indices 10 to 13 hold the four control and status bytes A, B, C and D. Indices 14 to 63 are general-purpose RAM.

Some bits belong to the clock and not to the host. Bytes C and D, the top bit of A and the top bit of the seconds byte come from dedicated status inputs, and host writes leave them unchanged. The counting logic is not part of this block. An external updater port writes the time bytes directly and takes precedence over a host write to the same byte in the same cycle. Read data is registered: it changes on the clock edge that ends a read cycle and holds between reads.

Top module: `rtcx_regfile`

## Requirements
- R1: After reset the index is 0, every stored byte is 0 and `bus_rdata` is 0.
- R2: A cycle with `bus_cs`=1, `bus_we`=1 and `bus_sel`=0 loads `bus_wdata[5:0]` into the index. A read with `bus_sel`=0 returns the index in bits 5:0, and bits 7:6 read as 0.
- R3: `bus_rdata` is registered and updates only at the edge that ends a cycle with `bus_cs`=1 and `bus_re`=1. The value returned comes from the state before any write made on that same edge, and this includes a write to the index. In every other cycle `bus_rdata` holds its value.
- R4: Indices 12 (byte C) and 13 (byte D) read the live values of `ro_stat_c` and `ro_stat_d`. Host writes to these indices change nothing.
- R5: Index 10 (byte A) reads `ro_ctla_msb` in bit 7. Bits 6:0 of that byte are host-writable.
- R6: Index 0 (seconds) reads `ro_sec_msb` in bit 7. Bits 6:0 of that byte are host-writable.
- R7: While `bus_cs`=0, neither writes nor reads have any effect: the index and the stored bytes stay unchanged, and `bus_rdata` holds.
- R8: When `tick_we`=1 and `tick_idx`<10, the bytes `tick_wdata` are written into time byte `tick_idx`. This write wins over a host write to the same byte in the same cycle. A `tick_idx` of 10 or more is ignored.
- R9: Indices 1 to 9, 11 and 14 to 63 are plain 8-bit read/write storage through the data window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Host chip select, active high |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_sel | input | 1 | 0 selects the index register, 1 selects the data window |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| tick_we | input | 1 | Updater write enable for time bytes |
| tick_idx | input | 4 | Updater target time byte |
| tick_wdata | input | 8 | Updater write data |
| ro_sec_msb | input | 1 | Status bit shown in bit 7 of the seconds byte |
| ro_ctla_msb | input | 1 | Status bit shown in bit 7 of byte A |
| ro_stat_c | input | 8 | Contents of byte C |
| ro_stat_d | input | 8 | Contents of byte D |

## Verification
The checker relies on the status inputs being sampled on the read edge, so that `$past` of `ro_stat_c` or of the msb inputs gives the value returned. It also relies on the index being a power-of-two range, so every index value names a real byte. The bench changes the status inputs only between clock edges, on the falling edge, and gives each cycle one fully defined set of strobes. Random phases mix strobes while chip select is off, updater writes with out-of-range indices, and collisions between the host and the updater, and a behavioural model tracks all of these on every cycle.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;
   // Position of the seconds byte in the time group
   localparam int SEC_IDX    = 0;
   // Offsets of control/status bytes after the time group
   localparam int CTL_A_OFS  = 0;
   localparam int CTL_B_OFS  = 1;
   localparam int CTL_C_OFS  = 2;
   localparam int CTL_D_OFS  = 3;
   localparam int CTL_COUNT  = 4;

   typedef enum logic [1:0] {
      BYTE_FULL   = 2'd0,  // all bits host-writable
      BYTE_MSB_RO = 2'd1,  // msb comes from a status input
      BYTE_ALL_RO = 2'd2   // whole byte comes from a status input
   } byte_kind_e;

   function automatic byte_kind_e kind_of(input int i, input int n_time);
      if (i == SEC_IDX || i == n_time + CTL_A_OFS)
         return BYTE_MSB_RO;
      if (i == n_time + CTL_C_OFS || i == n_time + CTL_D_OFS)
         return BYTE_ALL_RO;
      return BYTE_FULL;
   endfunction
endpackage

// File: rtl/rtcx_index_reg.sv
module rtcx_index_reg #(
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [IW-1:0] wdata,
   output logic [IW-1:0] idx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (load)
         idx_q <= wdata;
   end
endmodule

// File: rtl/rtcx_store.sv
module rtcx_store
   import rtcx_pkg::*;
#(
   parameter int DW     = 8,
   parameter int NREGS  = 64,
   parameter int N_TIME = 10,
   parameter int IW     = 6,
   parameter int TW     = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        host_we,
   input  logic [IW-1:0]               host_idx,
   input  logic [DW-1:0]               host_wdata,
   input  logic                        tick_we,
   input  logic [TW-1:0]               tick_idx,
   input  logic [DW-1:0]               tick_wdata,
   output logic [NREGS-1:0][DW-1:0]    q
);
   localparam logic [DW-1:0] MASK_FULL = '1;
   localparam logic [DW-1:0] MASK_LOW  = {1'b0, {(DW-1){1'b1}}};

   for (genvar i = 0; i < NREGS; i++) begin : g_byte
      localparam byte_kind_e KIND = kind_of(i, N_TIME);
      localparam logic [DW-1:0] WMASK = (KIND == BYTE_MSB_RO) ? MASK_LOW : MASK_FULL;

      if (KIND == BYTE_ALL_RO) begin : g_none
         assign q[i] = '0;
      end else begin : g_flop
         logic          host_hit;
         logic          tick_hit;
         logic [DW-1:0] r;

         assign host_hit = host_we && (host_idx == IW'(i));
         if (i < N_TIME) begin : g_tick
            assign tick_hit = tick_we && (tick_idx == TW'(i));
         end else begin : g_notick
            assign tick_hit = 1'b0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= '0;
            else if (tick_hit)
               r <= tick_wdata & WMASK;
            else if (host_hit)
               r <= host_wdata & WMASK;
         end
         assign q[i] = r;
      end
   end
endmodule

// File: rtl/rtcx_rd_mux.sv
module rtcx_rd_mux
   import rtcx_pkg::*;
#(
   parameter int DW       = 8,
   parameter int NREGS    = 64,
   parameter int N_TIME   = 10,
   parameter int IW       = 6,
   parameter int READ_REG = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic                     sel,
   input  logic [IW-1:0]            idx,
   input  logic [NREGS-1:0][DW-1:0] store_q,
   input  logic                     sec_msb,
   input  logic                     ctla_msb,
   input  logic [DW-1:0]            stat_c,
   input  logic [DW-1:0]            stat_d,
   output logic [DW-1:0]            rdata
);
   localparam int IDX_A = N_TIME + CTL_A_OFS;
   localparam int IDX_C = N_TIME + CTL_C_OFS;

   logic [NREGS-1:0][DW-1:0] view;
   logic [DW-1:0]            rd_val;

   // Read-only bits: the stored copy of them is always zero, so OR merges.
   for (genvar i = 0; i < NREGS; i++) begin : g_view
      localparam byte_kind_e KIND = kind_of(i, N_TIME);
      if (KIND == BYTE_MSB_RO) begin : g_msb
         logic msb_src;
         assign msb_src = (i == IDX_A) ? ctla_msb : sec_msb;
         assign view[i] = store_q[i] | {msb_src, {(DW-1){1'b0}}};
      end else if (KIND == BYTE_ALL_RO) begin : g_stat
         assign view[i] = store_q[i] | ((i == IDX_C) ? stat_c : stat_d);
      end else begin : g_plain
         assign view[i] = store_q[i];
      end
   end

   assign rd_val = sel ? view[idx] : DW'(idx);

   if (READ_REG != 0) begin : g_reg
      logic [DW-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata_q <= '0;
         else if (rd_en)
            rdata_q <= rd_val;
      end
      assign rdata = rdata_q;
   end else begin : g_comb
      assign rdata = rd_en ? rd_val : '0;
   end
endmodule

// File: rtl/rtcx_regfile.sv
module rtcx_regfile
   import rtcx_pkg::*;
#(
   parameter int DW       = 8,
   parameter int NREGS    = 64,
   parameter int N_TIME   = 10,
   parameter int READ_REG = 1,
   parameter int TW       = $clog2(N_TIME)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_cs,
   input  logic          bus_we,
   input  logic          bus_re,
   input  logic          bus_sel,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          tick_we,
   input  logic [TW-1:0] tick_idx,
   input  logic [DW-1:0] tick_wdata,
   input  logic          ro_sec_msb,
   input  logic          ro_ctla_msb,
   input  logic [DW-1:0] ro_stat_c,
   input  logic [DW-1:0] ro_stat_d
);
   localparam int IW = $clog2(NREGS);

   // Elaboration-time parameter checks
   if (NREGS != (1 << IW)) begin : g_bad_nregs
      $error("NREGS must be a power of two");
   end
   if (IW >= DW) begin : g_bad_iw
      $error("index must be narrower than the data bus");
   end
   if (N_TIME < 1 || N_TIME + CTL_COUNT > NREGS) begin : g_bad_time
      $error("time and control groups do not fit");
   end
   if (TW < $clog2(N_TIME) || TW < 1) begin : g_bad_tw
      $error("tick index too narrow");
   end
   if (DW < 2) begin : g_bad_dw
      $error("data width too small");
   end

   logic                     wr_idx;
   logic                     wr_dat;
   logic                     rd_en;
   logic [IW-1:0]            idx_q;
   logic [NREGS-1:0][DW-1:0] store_q;

   assign wr_idx = bus_cs & bus_we & ~bus_sel;
   assign wr_dat = bus_cs & bus_we & bus_sel;
   assign rd_en  = bus_cs & bus_re;

   rtcx_index_reg #(.IW(IW)) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wr_idx),
      .wdata (bus_wdata[IW-1:0]),
      .idx_q (idx_q)
   );

   rtcx_store #(
      .DW(DW), .NREGS(NREGS), .N_TIME(N_TIME), .IW(IW), .TW(TW)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (wr_dat),
      .host_idx   (idx_q),
      .host_wdata (bus_wdata),
      .tick_we    (tick_we),
      .tick_idx   (tick_idx),
      .tick_wdata (tick_wdata),
      .q          (store_q)
   );

   rtcx_rd_mux #(
      .DW(DW), .NREGS(NREGS), .N_TIME(N_TIME), .IW(IW), .READ_REG(READ_REG)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .sel      (bus_sel),
      .idx      (idx_q),
      .store_q  (store_q),
      .sec_msb  (ro_sec_msb),
      .ctla_msb (ro_ctla_msb),
      .stat_c   (ro_stat_c),
      .stat_d   (ro_stat_d),
      .rdata    (bus_rdata)
   );
endmodule

// File: rtl/rtcx_regfile_chk.sv
module rtcx_regfile_chk
   import rtcx_pkg::*;
#(
   parameter int DW       = 8,
   parameter int IW       = 6,
   parameter int N_TIME   = 10,
   parameter int READ_REG = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_cs,
   input logic          bus_we,
   input logic          bus_re,
   input logic          bus_sel,
   input logic [DW-1:0] bus_wdata,
   input logic [DW-1:0] bus_rdata,
   input logic [IW-1:0] idx_q,
   input logic          ro_sec_msb,
   input logic          ro_ctla_msb,
   input logic [DW-1:0] ro_stat_c
);
   localparam logic [IW-1:0] IX_SEC = IW'(SEC_IDX);
   localparam logic [IW-1:0] IX_A   = IW'(N_TIME + CTL_A_OFS);
   localparam logic [IW-1:0] IX_C   = IW'(N_TIME + CTL_C_OFS);

   // R2: index load from the bus
   p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && bus_we && !bus_sel) |=> (idx_q == $past(bus_wdata[IW-1:0])));

   // R7: deselected host leaves the index alone
   p_index_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cs |=> $stable(idx_q));

   if (READ_REG != 0) begin : g_reg_props
      // R3: read data holds outside read cycles
      p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !(bus_cs && bus_re) |=> $stable(bus_rdata));

      // R2: index readback, upper bits zero
      p_index_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_cs && bus_re && !bus_sel) |=> (bus_rdata == DW'($past(idx_q))));

      // R4: byte C mirrors its status input
      p_stat_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_cs && bus_re && bus_sel && idx_q == IX_C) |=> (bus_rdata == $past(ro_stat_c)));

      // R5: byte A msb comes from its status input
      p_ctla_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_cs && bus_re && bus_sel && idx_q == IX_A) |=> (bus_rdata[DW-1] == $past(ro_ctla_msb)));

      // R6: seconds msb comes from its status input
      p_sec_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_cs && bus_re && bus_sel && idx_q == IX_SEC) |=> (bus_rdata[DW-1] == $past(ro_sec_msb)));
   end
endmodule

bind rtcx_regfile rtcx_regfile_chk #(
   .DW(DW), .IW(IW), .N_TIME(N_TIME), .READ_REG(READ_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_cs      (bus_cs),
   .bus_we      (bus_we),
   .bus_re      (bus_re),
   .bus_sel     (bus_sel),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .idx_q       (idx_q),
   .ro_sec_msb  (ro_sec_msb),
   .ro_ctla_msb (ro_ctla_msb),
   .ro_stat_c   (ro_stat_c)
);

// File: tb/rtcx_regfile_tb_top.sv
module rtcx_regfile_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_cs = 1'b0, bus_we = 1'b0, bus_re = 1'b0, bus_sel = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       tick_we = 1'b0;
   logic [3:0] tick_idx = 4'h0;
   logic [7:0] tick_wdata = 8'h00;
   logic       ro_sec_msb = 1'b0, ro_ctla_msb = 1'b0;
   logic [7:0] ro_stat_c = 8'h00, ro_stat_d = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtcx_regfile dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_we(tick_we), .tick_idx(tick_idx), .tick_wdata(tick_wdata),
      .ro_sec_msb(ro_sec_msb), .ro_ctla_msb(ro_ctla_msb),
      .ro_stat_c(ro_stat_c), .ro_stat_d(ro_stat_d)
   );

   // Behavioural reference state
   int         vectors = 0;
   int         miscompares = 0;
   int         ref_idx = 0;
   int         ref_mem [64];
   logic [7:0] ref_rd = 8'h00;
   bit         finished = 0;

   function automatic logic [7:0] ref_view(input int i);
      case (i)
         0:  return {ro_sec_msb, 7'(ref_mem[0])};
         10: return {ro_ctla_msb, 7'(ref_mem[10])};
         12: return ro_stat_c;
         13: return ro_stat_d;
         default: return 8'(ref_mem[i]);
      endcase
   endfunction

   task automatic compare(input string tag);
      vectors++;
      if (bus_rdata !== ref_rd) begin
         miscompares++;
         $display("FAIL %s: rdata=%h expected %h", tag, bus_rdata, ref_rd);
      end
   endtask

   // One cycle: drive at the falling edge, advance the model, compare at the next falling edge
   task automatic cyc(input logic cs, we, re, sel, input logic [7:0] wd,
                      input logic twe, input logic [3:0] tix, input logic [7:0] twd,
                      input string tag);
      int msk;
      bus_cs = cs; bus_we = we; bus_re = re; bus_sel = sel; bus_wdata = wd;
      tick_we = twe; tick_idx = tix; tick_wdata = twd;
      if (cs && re)
         ref_rd = sel ? ref_view(ref_idx) : 8'(ref_idx);
      if (cs && we) begin
         if (!sel) ref_idx = int'(wd) % 64;
         else if (ref_idx != 12 && ref_idx != 13) begin
            msk = (ref_idx == 0 || ref_idx == 10) ? 'h7f : 'hff;
            ref_mem[ref_idx] = int'(wd) & msk;
         end
      end
      if (twe && tix < 10)
         ref_mem[tix] = int'(twd) & ((tix == 0) ? 'h7f : 'hff);
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic set_idx(input int i, input string tag);
      cyc(1, 1, 0, 0, 8'(i), 0, 0, 0, tag);
   endtask
   task automatic wr_dat(input logic [7:0] d, input string tag);
      cyc(1, 1, 0, 1, d, 0, 0, 0, tag);
   endtask
   task automatic rd_dat(input string tag);
      cyc(1, 0, 1, 1, 0, 0, 0, 0, tag);
   endtask
   task automatic rd_idx(input string tag);
      cyc(1, 0, 1, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not end, rdata=%h expected %h", bus_rdata, ref_rd);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) ref_mem[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare("R1 reset rdata");
      rd_idx("R1 reset index");
      ro_sec_msb = 1'b0;
      rd_dat("R1 reset seconds byte");

      // Index load, upper bits dropped
      set_idx(8'hff, "R2 index load");
      rd_idx("R2 index readback 0x3f");
      set_idx(8'h55, "R2 index load");
      rd_idx("R2 index readback 0x15");

      // Plain storage throughout the space
      for (int i = 0; i < 64; i++) begin
         set_idx(i, "R9 select");
         wr_dat(8'((i * 37) ^ 8'ha5), "R9 write");
      end
      for (int i = 0; i < 64; i++) begin
         set_idx(i, "R9 select");
         rd_dat("R9 readback");
      end

      // Read-only status bytes
      ro_stat_c = 8'h3c; ro_stat_d = 8'hc3;
      set_idx(12, "R4 select C");
      wr_dat(8'hff, "R4 write C");
      rd_dat("R4 read C");
      ro_stat_c = 8'h81;
      rd_dat("R4 read C live");
      set_idx(13, "R4 select D");
      wr_dat(8'h00, "R4 write D");
      rd_dat("R4 read D");

      // msb of A and seconds
      set_idx(10, "R5 select A");
      ro_ctla_msb = 1'b1;
      wr_dat(8'h00, "R5 write A");
      rd_dat("R5 read A msb 1");
      ro_ctla_msb = 1'b0;
      wr_dat(8'hff, "R5 write A");
      rd_dat("R5 read A msb 0");
      set_idx(0, "R6 select seconds");
      ro_sec_msb = 1'b0;
      wr_dat(8'hff, "R6 write seconds");
      rd_dat("R6 read seconds msb 0");
      ro_sec_msb = 1'b1;
      wr_dat(8'h12, "R6 write seconds");
      rd_dat("R6 read seconds msb 1");

      // Read ordering: same-edge write and read
      set_idx(20, "R3 select");
      cyc(1, 1, 1, 1, 8'h99, 0, 0, 0, "R3 read sees old byte");
      rd_dat("R3 read sees new byte");
      cyc(1, 1, 1, 0, 8'd30, 0, 0, 0, "R3 read sees old index");
      cyc(0, 0, 0, 1, 8'h00, 0, 0, 0, "R3 hold");

      // Deselected host
      cyc(0, 1, 1, 0, 8'd5, 0, 0, 0, "R7 index write ignored");
      cyc(0, 1, 1, 1, 8'h77, 0, 0, 0, "R7 data write ignored");
      rd_idx("R7 index unchanged");
      rd_dat("R7 byte unchanged");

      // Updater
      set_idx(3, "R8 select");
      cyc(1, 1, 0, 1, 8'h11, 1, 4'd3, 8'h22, "R8 collision");
      rd_dat("R8 updater wins");
      cyc(0, 0, 0, 0, 8'h00, 1, 4'd12, 8'hee, "R8 out of range");
      set_idx(12, "R8 select C");
      rd_dat("R8 C unaffected");
      set_idx(11, "R8 select B");
      rd_dat("R8 B unaffected");
      cyc(0, 0, 0, 0, 8'h00, 1, 4'd0, 8'hff, "R8 seconds update");
      set_idx(0, "R8 select seconds");
      rd_dat("R8 seconds read");

      // Random mix against the model
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r;
         r = $urandom;
         ro_sec_msb  = r[20];
         ro_ctla_msb = r[21];
         ro_stat_c   = 8'($urandom);
         ro_stat_d   = 8'($urandom);
         cyc(r[0] | r[1], r[2], r[3], r[4], 8'($urandom),
             r[5] & r[6], 4'(r[11:8]), 8'($urandom), "R3 random mix");
      end
      finish_run();
   end
endmodule